// File: doc/BRIEF.md
# Indirect Memory Access Window

This block gives a host register bus a way to reach two internal spaces it cannot map directly: a dword-addressed SRAM and a bank of peripheral registers. Each space has a pointer register and a data register. The host loads a pointer first. Each later access to the matching data register turns into one internal request. SRAM reads and writes use separate pointers. Each pointer moves forward by one dword (4 bytes) every time its data register is used, so the host can stream a block of SRAM with a single pointer load.

Peripheral pointers hold a 16-bit register offset and a 2-bit transfer size. These pointers never move. Transfers smaller than a dword are narrowed on the way out with byte enables and zeroed write bytes. On the way back, the unused upper read bytes are cleared. A read of either data register holds the host bus stalled until the internal response arrives.

Top module: `indirect_access_win`

## Requirements
- R1: After reset, all four pointer registers read back as zero and no internal request is issued. A data access made before any pointer load therefore uses address zero.
- R2: The window base is 0x400. The offsets from the base are: SRAM read pointer 0x0C, SRAM write pointer 0x10, SRAM write data 0x18, SRAM read data 0x1C, peripheral write pointer 0x44, peripheral read pointer 0x48, peripheral write data 0x4C, peripheral read data 0x50. An internal request is issued only while a host access is present.
- R3: A host write to SRAM write data issues one SRAM write request in the same cycle. The request carries the write pointer as its address and the host data. The write pointer then increases by 4.
- R4: A host read of SRAM read data issues one SRAM read request at the read pointer and returns the SRAM response data. The read pointer then increases by 4.
- R5: The two SRAM pointers are independent. A data write never changes the read pointer, and a data read never changes the write pointer.
- R6: A pointer register reads back its current value, including all increments applied so far.
- R7: A peripheral pointer keeps only bits 15:0 (register offset) and bits 25:24 (size, where the byte count is size+1). All other bits read back as zero.
- R8: A peripheral write drives the offset from the write pointer. It drives byte enables with the low size+1 bits set (size 0 gives 0x1, 1 gives 0x3, 2 gives 0x7, 3 gives 0xF). Write data bytes outside the enabled bytes are zero.
- R9: A peripheral read returns the response with every byte above the low size+1 bytes cleared to zero.
- R10: Peripheral pointers do not move on data accesses. Repeated transfers use the same offset and size.
- R11: Host writes and reads of non-data offsets complete with ready high in the same cycle. A data read holds ready low from the issue cycle until the cycle in which the internal response is valid. While a data read waits, no further internal request is issued.
- R12: A read of an offset that is not mapped completes at once and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Host register address |
| we_i | input | 1 | Host write strobe, held until ready |
| re_i | input | 1 | Host read strobe, held until ready |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data, valid while ready is high |
| ready_o | output | 1 | Host access completes this cycle |
| sram_req_o | output | 1 | SRAM request strobe |
| sram_we_o | output | 1 | SRAM request is a write |
| sram_addr_o | output | 32 | SRAM byte address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rvalid_i | input | 1 | SRAM read response valid |
| sram_rdata_i | input | 32 | SRAM read response data |
| prph_req_o | output | 1 | Peripheral request strobe |
| prph_we_o | output | 1 | Peripheral request is a write |
| prph_addr_o | output | 16 | Peripheral register offset |
| prph_be_o | output | 4 | Peripheral byte enables |
| prph_wdata_o | output | 32 | Peripheral write data, disabled bytes zero |
| prph_rvalid_i | input | 1 | Peripheral read response valid |
| prph_rdata_i | input | 32 | Peripheral read response data |

## Verification
The SRAM path is driven with a write burst and then a read burst of three dwords each. Three things separate an auto-increment fault from a pointer mix-up: the logged request addresses, the returned data, and the read-back of both pointers. A data write issued before any pointer load shows whether reset leaves the pointers at zero.

The peripheral path uses two sizes of write to the same offset, and reads at sizes 0, 2 and 3 from a model whose unwritten bytes are nonzero. Together these expose wrong byte enables, unmasked data bytes and any unwanted pointer movement. Stall counts on data reads, set against the model latency, separate correct stalling from early or missing ready.

// File: rtl/iaw_pkg.sv
package iaw_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned BEW = DW / 8;

  localparam logic [7:0] OFS_MEM_RA = 8'h0C;
  localparam logic [7:0] OFS_MEM_WA = 8'h10;
  localparam logic [7:0] OFS_MEM_WD = 8'h18;
  localparam logic [7:0] OFS_MEM_RD = 8'h1C;
  localparam logic [7:0] OFS_PR_WA  = 8'h44;
  localparam logic [7:0] OFS_PR_RA  = 8'h48;
  localparam logic [7:0] OFS_PR_WD  = 8'h4C;
  localparam logic [7:0] OFS_PR_RD  = 8'h50;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_MEM_RA, SEL_MEM_WA, SEL_MEM_WD, SEL_MEM_RD,
    SEL_PR_WA, SEL_PR_RA, SEL_PR_WD, SEL_PR_RD
  } win_sel_e;

  function automatic logic [BEW-1:0] size_to_be(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/iaw_decode.sv
module iaw_decode
  import iaw_pkg::*;
#(
  parameter int unsigned          HOST_AW  = 12,
  parameter logic [HOST_AW-1:0]   WIN_BASE = 12'h400
) (
  input  logic [HOST_AW-1:0] addr_i,
  output win_sel_e           sel_o
);
  logic [HOST_AW-1:0] ofs;
  logic               in_win;

  assign ofs    = addr_i - WIN_BASE;
  assign in_win = (addr_i >= WIN_BASE) && (ofs < HOST_AW'(256));

  always_comb begin
    sel_o = SEL_NONE;
    if (in_win) begin
      case (ofs[7:0])
        OFS_MEM_RA: sel_o = SEL_MEM_RA;
        OFS_MEM_WA: sel_o = SEL_MEM_WA;
        OFS_MEM_WD: sel_o = SEL_MEM_WD;
        OFS_MEM_RD: sel_o = SEL_MEM_RD;
        OFS_PR_WA:  sel_o = SEL_PR_WA;
        OFS_PR_RA:  sel_o = SEL_PR_RA;
        OFS_PR_WD:  sel_o = SEL_PR_WD;
        OFS_PR_RD:  sel_o = SEL_PR_RD;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/iaw_mem_ptr.sv
module iaw_mem_ptr #(
  parameter int unsigned MAW  = 32,
  parameter int unsigned STEP = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_raddr_i,
  input  logic           ld_waddr_i,
  input  logic [MAW-1:0] ld_val_i,
  input  logic           rd_fire_i,
  input  logic           wr_fire_i,
  output logic [MAW-1:0] raddr_o,
  output logic [MAW-1:0] waddr_o
);
  localparam logic [MAW-1:0] INC = MAW'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raddr_o <= '0;
      waddr_o <= '0;
    end else begin
      if (ld_raddr_i)     raddr_o <= ld_val_i;
      else if (rd_fire_i) raddr_o <= raddr_o + INC;
      if (ld_waddr_i)     waddr_o <= ld_val_i;
      else if (wr_fire_i) waddr_o <= waddr_o + INC;
    end
  end

  // R3
  wr_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_i && !ld_waddr_i) |=> (waddr_o == $past(waddr_o) + INC));
  // R5
  rd_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_i && !ld_raddr_i) |=> $stable(raddr_o));
endmodule

// File: rtl/iaw_prph_regs.sv
module iaw_prph_regs
  import iaw_pkg::*;
#(
  parameter int unsigned PAW    = 16,
  parameter int unsigned SZ_LSB = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ld_wa_i,
  input  logic           ld_ra_i,
  input  logic [DW-1:0]  hwdata_i,
  input  logic           wr_fire_i,
  input  logic [DW-1:0]  rsp_rdata_i,
  output logic [DW-1:0]  wa_rb_o,
  output logic [DW-1:0]  ra_rb_o,
  output logic [PAW-1:0] req_addr_o,
  output logic [BEW-1:0] be_o,
  output logic [DW-1:0]  wdata_o,
  output logic [DW-1:0]  rdata_o
);
  logic [PAW-1:0] wofs_q, rofs_q;
  logic [1:0]     wsz_q, rsz_q;
  logic [BEW-1:0] rbe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wofs_q <= '0; wsz_q <= '0;
      rofs_q <= '0; rsz_q <= '0;
    end else begin
      if (ld_wa_i) begin
        wofs_q <= hwdata_i[PAW-1:0];
        wsz_q  <= hwdata_i[SZ_LSB +: 2];
      end
      if (ld_ra_i) begin
        rofs_q <= hwdata_i[PAW-1:0];
        rsz_q  <= hwdata_i[SZ_LSB +: 2];
      end
    end
  end

  always_comb begin
    wa_rb_o = '0;
    wa_rb_o[PAW-1:0]      = wofs_q;
    wa_rb_o[SZ_LSB +: 2]  = wsz_q;
    ra_rb_o = '0;
    ra_rb_o[PAW-1:0]      = rofs_q;
    ra_rb_o[SZ_LSB +: 2]  = rsz_q;
  end

  assign req_addr_o = wr_fire_i ? wofs_q : rofs_q;
  assign be_o       = size_to_be(wsz_q);
  assign rbe        = size_to_be(rsz_q);

  for (genvar b = 0; b < BEW; b++) begin : g_lane
    assign wdata_o[b*8 +: 8] = be_o[b] ? hwdata_i[b*8 +: 8]    : 8'h00;
    assign rdata_o[b*8 +: 8] = rbe[b]  ? rsp_rdata_i[b*8 +: 8] : 8'h00;
  end

  // R10
  wr_ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_i && !ld_wa_i) |=> ($stable(wofs_q) && $stable(wsz_q)));
endmodule

// File: rtl/indirect_access_win.sv
module indirect_access_win
  import iaw_pkg::*;
#(
  parameter int unsigned        HOST_AW  = 12,
  parameter logic [HOST_AW-1:0] WIN_BASE = 12'h400,
  parameter int unsigned        MAW      = 32,
  parameter int unsigned        PAW      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               ready_o,
  output logic               sram_req_o,
  output logic               sram_we_o,
  output logic [MAW-1:0]     sram_addr_o,
  output logic [31:0]        sram_wdata_o,
  input  logic               sram_rvalid_i,
  input  logic [31:0]        sram_rdata_i,
  output logic               prph_req_o,
  output logic               prph_we_o,
  output logic [PAW-1:0]     prph_addr_o,
  output logic [3:0]         prph_be_o,
  output logic [31:0]        prph_wdata_o,
  input  logic               prph_rvalid_i,
  input  logic [31:0]        prph_rdata_i
);
  win_sel_e       sel;
  logic           busy_q, wait_prph_q;
  logic           wr_ok, rd_ok;
  logic           mem_wr_fire, mem_rd_fire, pr_wr_fire, pr_rd_fire;
  logic [MAW-1:0] mem_raddr, mem_waddr;
  logic [DW-1:0]  pr_wa_rb, pr_ra_rb, pr_rdata;
  logic           rsp_done;

  iaw_decode #(.HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_ok       = we_i && !busy_q;
  assign rd_ok       = re_i && !we_i && !busy_q;
  assign mem_wr_fire = wr_ok && (sel == SEL_MEM_WD);
  assign mem_rd_fire = rd_ok && (sel == SEL_MEM_RD);
  assign pr_wr_fire  = wr_ok && (sel == SEL_PR_WD);
  assign pr_rd_fire  = rd_ok && (sel == SEL_PR_RD);

  iaw_mem_ptr #(.MAW(MAW), .STEP(4)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_raddr_i (wr_ok && (sel == SEL_MEM_RA)),
    .ld_waddr_i (wr_ok && (sel == SEL_MEM_WA)),
    .ld_val_i   (MAW'(wdata_i)),
    .rd_fire_i  (mem_rd_fire),
    .wr_fire_i  (mem_wr_fire),
    .raddr_o    (mem_raddr),
    .waddr_o    (mem_waddr)
  );

  iaw_prph_regs #(.PAW(PAW), .SZ_LSB(24)) u_prph (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_wa_i     (wr_ok && (sel == SEL_PR_WA)),
    .ld_ra_i     (wr_ok && (sel == SEL_PR_RA)),
    .hwdata_i    (wdata_i),
    .wr_fire_i   (pr_wr_fire),
    .rsp_rdata_i (prph_rdata_i),
    .wa_rb_o     (pr_wa_rb),
    .ra_rb_o     (pr_ra_rb),
    .req_addr_o  (prph_addr_o),
    .be_o        (prph_be_o),
    .wdata_o     (prph_wdata_o),
    .rdata_o     (pr_rdata)
  );

  assign sram_req_o   = mem_wr_fire || mem_rd_fire;
  assign sram_we_o    = mem_wr_fire;
  assign sram_addr_o  = mem_wr_fire ? mem_waddr : mem_raddr;
  assign sram_wdata_o = wdata_i;
  assign prph_req_o   = pr_wr_fire || pr_rd_fire;
  assign prph_we_o    = pr_wr_fire;

  assign rsp_done = busy_q && (wait_prph_q ? prph_rvalid_i : sram_rvalid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      wait_prph_q <= 1'b0;
    end else if (mem_rd_fire || pr_rd_fire) begin
      busy_q      <= 1'b1;
      wait_prph_q <= pr_rd_fire;
    end else if (rsp_done) begin
      busy_q      <= 1'b0;
    end
  end

  always_comb begin
    ready_o = 1'b0;
    rdata_o = '0;
    if (busy_q) begin
      ready_o = rsp_done;
      if (rsp_done) rdata_o = wait_prph_q ? pr_rdata : sram_rdata_i;
    end else if (we_i) begin
      ready_o = 1'b1;
    end else if (re_i) begin
      ready_o = 1'b1;
      case (sel)
        SEL_MEM_RA: rdata_o = 32'(mem_raddr);
        SEL_MEM_WA: rdata_o = 32'(mem_waddr);
        SEL_PR_WA:  rdata_o = pr_wa_rb;
        SEL_PR_RA:  rdata_o = pr_ra_rb;
        SEL_MEM_RD, SEL_PR_RD: ready_o = 1'b0;
        default:    rdata_o = '0;
      endcase
    end
  end

  // R11
  rd_not_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && !sram_we_o) |-> !ready_o);
  // R11
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (!sram_req_o && !prph_req_o));
  // R2
  req_needs_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o || prph_req_o) |-> (we_i || re_i));
  // R8
  wdata_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prph_req_o && prph_we_o) |->
      ((prph_wdata_o & ~{{8{prph_be_o[3]}}, {8{prph_be_o[2]}},
                         {8{prph_be_o[1]}}, {8{prph_be_o[0]}}}) == 32'h0));
endmodule

// File: tb/indirect_access_win_tb_top.sv
`timescale 1ns/1ps
module indirect_access_win_tb_top;
  localparam int S_LAT = 3;
  localparam int P_LAT = 2;
  localparam logic [11:0] A_MRA = 12'h40C, A_MWA = 12'h410, A_MWD = 12'h418,
                          A_MRD = 12'h41C, A_PWA = 12'h444, A_PRA = 12'h448,
                          A_PWD = 12'h44C, A_PRD = 12'h450;

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = '0;
  logic we = 0, re = 0;
  logic [31:0] wdata = '0, rdata;
  logic ready;
  logic sram_req, sram_we, prph_req, prph_we;
  logic [31:0] sram_addr, sram_wdata, prph_wdata;
  logic [15:0] prph_addr;
  logic [3:0]  prph_be;
  logic s_rvalid = 0, p_rvalid = 0;
  logic [31:0] s_rdata = '0, p_rdata = '0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  indirect_access_win dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .sram_req_o(sram_req), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wdata), .sram_rvalid_i(s_rvalid), .sram_rdata_i(s_rdata),
    .prph_req_o(prph_req), .prph_we_o(prph_we), .prph_addr_o(prph_addr),
    .prph_be_o(prph_be), .prph_wdata_o(prph_wdata), .prph_rvalid_i(p_rvalid),
    .prph_rdata_i(p_rdata)
  );

  // SRAM and peripheral models
  logic [31:0] smem [64];
  logic [31:0] pmem [64];
  logic [31:0] s_wa_log [16];
  int          s_wa_n = 0;
  logic [15:0] p_last_addr = '0;
  logic [3:0]  p_last_be = '0;
  logic [31:0] p_last_wd = '0;
  int          req_cnt = 0;
  int          s_cnt = 0, p_cnt = 0;
  logic [31:0] s_pa = '0;
  logic [15:0] p_pa = '0;

  initial for (int i = 0; i < 64; i++) begin smem[i] = '0; pmem[i] = 32'hA5A5A5A5; end

  always @(posedge clk) begin
    s_rvalid <= 1'b0;
    p_rvalid <= 1'b0;
    if (sram_req || prph_req) req_cnt <= req_cnt + 1;
    if (sram_req) begin
      if (sram_we) begin
        smem[sram_addr[7:2]] <= sram_wdata;
        if (s_wa_n < 16) s_wa_log[s_wa_n] <= sram_addr;
        s_wa_n <= s_wa_n + 1;
      end else begin
        s_cnt <= S_LAT; s_pa <= sram_addr;
      end
    end else if (s_cnt > 0) begin
      if (s_cnt == 1) begin s_rvalid <= 1'b1; s_rdata <= smem[s_pa[7:2]]; end
      s_cnt <= s_cnt - 1;
    end
    if (prph_req) begin
      if (prph_we) begin
        for (int b = 0; b < 4; b++)
          if (prph_be[b]) pmem[prph_addr[7:2]][b*8 +: 8] <= prph_wdata[b*8 +: 8];
        p_last_addr <= prph_addr; p_last_be <= prph_be; p_last_wd <= prph_wdata;
      end else begin
        p_cnt <= P_LAT; p_pa <= prph_addr;
      end
    end else if (p_cnt > 0) begin
      if (p_cnt == 1) begin p_rvalid <= 1'b1; p_rdata <= pmem[p_pa[7:2]]; end
      p_cnt <= p_cnt - 1;
    end
  end

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    chk_eq("R11 write ready", {31'b0, ready}, 32'h1);
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d, output int stall);
    addr = a; re = 1; stall = 0;
    @(negedge clk);
    while (!ready && stall < 100) begin @(negedge clk); stall++; end
    d = rdata;
    @(posedge clk); #1;
    re = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; int st;
    chk_eq("R1 no sram req", {31'b0, sram_req}, 0);
    chk_eq("R1 no prph req", {31'b0, prph_req}, 0);
    host_rd(A_MRA, d, st); chk_eq("R1 mem rd ptr", d, 0);
    chk_eq("R11 ptr read no stall", st, 0);
    host_rd(A_MWA, d, st); chk_eq("R1 mem wr ptr", d, 0);
    host_rd(A_PWA, d, st); chk_eq("R1 prph wr ptr", d, 0);
    host_rd(A_PRA, d, st); chk_eq("R1 prph rd ptr", d, 0);
    host_wr(A_MWD, 32'h55);
    chk_eq("R1 write before load at 0", s_wa_log[0], 0);
    host_rd(A_MWA, d, st); chk_eq("R6 wr ptr after one write", d, 4);
  endtask

  task automatic t_sram_wr_burst;
    logic [31:0] d; int st; int base;
    host_wr(A_MWA, 32'h100);
    base = s_wa_n;
    host_wr(A_MWD, 32'hA0A0_0001);
    host_wr(A_MWD, 32'hB0B0_0002);
    host_wr(A_MWD, 32'hC0C0_0003);
    chk_eq("R3 burst addr 0", s_wa_log[base],   32'h100);
    chk_eq("R3 burst addr 1", s_wa_log[base+1], 32'h104);
    chk_eq("R3 burst addr 2", s_wa_log[base+2], 32'h108);
    chk_eq("R3 data stored", smem[6'h41], 32'hB0B0_0002);
    host_rd(A_MWA, d, st); chk_eq("R6 wr ptr readback", d, 32'h10C);
    host_rd(A_MRA, d, st); chk_eq("R5 rd ptr untouched by writes", d, 0);
  endtask

  task automatic t_sram_rd_burst;
    logic [31:0] d; int st; int rc;
    host_wr(A_MRA, 32'h100);
    host_rd(A_MRD, d, st); chk_eq("R4 read 0", d, 32'hA0A0_0001);
    chk_eq("R11 sram read stall", st, S_LAT + 1);
    host_rd(A_MRD, d, st); chk_eq("R4 read 1", d, 32'hB0B0_0002);
    rc = req_cnt;
    host_rd(A_MRD, d, st); chk_eq("R4 read 2", d, 32'hC0C0_0003);
    chk_eq("R11 one request per read", req_cnt - rc, 1);
    host_rd(A_MRA, d, st); chk_eq("R6 rd ptr readback", d, 32'h10C);
    host_rd(A_MWA, d, st); chk_eq("R5 wr ptr untouched by reads", d, 32'h10C);
  endtask

  task automatic t_prph_ptr;
    logic [31:0] d; int st;
    host_wr(A_PWA, 32'hFFFF_FFFF);
    host_rd(A_PWA, d, st); chk_eq("R7 wr ptr field mask", d, 32'h0300_FFFF);
    host_wr(A_PRA, 32'h5A5A_1234);
    host_rd(A_PRA, d, st); chk_eq("R7 rd ptr field mask", d, 32'h0200_1234);
  endtask

  task automatic t_prph_wr;
    logic [31:0] d; int st;
    host_wr(A_PWA, 32'h0100_0020);
    host_wr(A_PWD, 32'hAABB_CCDD);
    chk_eq("R8 half addr", p_last_addr, 32'h20);
    chk_eq("R8 half be", p_last_be, 32'h3);
    chk_eq("R8 half wdata", p_last_wd, 32'h0000_CCDD);
    host_wr(A_PWD, 32'h1122_3344);
    chk_eq("R10 same addr again", p_last_addr, 32'h20);
    chk_eq("R10 same be again", p_last_be, 32'h3);
    host_rd(A_PWA, d, st); chk_eq("R10 ptr unchanged", d, 32'h0100_0020);
    host_wr(A_PWA, 32'h0300_0024);
    host_wr(A_PWD, 32'h1122_3344);
    chk_eq("R8 dword be", p_last_be, 32'hF);
    chk_eq("R8 dword wdata", p_last_wd, 32'h1122_3344);
    host_wr(A_PWA, 32'h0000_0028);
    host_wr(A_PWD, 32'hFFFF_FF77);
    chk_eq("R8 byte be", p_last_be, 32'h1);
    chk_eq("R8 byte wdata", p_last_wd, 32'h0000_0077);
  endtask

  task automatic t_prph_rd;
    logic [31:0] d; int st;
    host_wr(A_PRA, 32'h0300_0020);
    host_rd(A_PRD, d, st); chk_eq("R8 partial write kept upper", d, 32'hA5A5_3344);
    chk_eq("R11 prph read stall", st, P_LAT + 1);
    host_wr(A_PRA, 32'h0000_0024);
    host_rd(A_PRD, d, st); chk_eq("R9 size0 read", d, 32'h0000_0044);
    host_rd(A_PRD, d, st); chk_eq("R10 repeat read", d, 32'h0000_0044);
    host_wr(A_PRA, 32'h0200_0024);
    host_rd(A_PRD, d, st); chk_eq("R9 size2 read", d, 32'h0022_3344);
    host_wr(A_PRA, 32'h0300_0028);
    host_rd(A_PRD, d, st); chk_eq("R9 size3 read", d, 32'hA5A5_A577);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; int st; int rc;
    rc = req_cnt;
    host_rd(12'h400, d, st); chk_eq("R12 unmapped data", d, 0);
    chk_eq("R12 unmapped no stall", st, 0);
    host_rd(12'h0C, d, st); chk_eq("R2 below base unmapped", d, 0);
    chk_eq("R2 no request for other offsets", req_cnt - rc, 0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_sram_wr_burst();
    t_sram_rd_burst();
    t_prph_ptr();
    t_prph_wr();
    t_prph_rd();
    t_unmapped();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
    report();
  end
endmodule